// File: doc/BRIEF.md
# Front Sync Serial Frame Generator

This block serializes the per-line synchronisation data of a video front end onto one wire that the rest of the video path listens to. A short parallel word is loaded: a sub-line phase value (skew), a field identifier and a vertical-blanking flag. The block then sends it as a fixed sequence of bit slots. The sequence begins with a low marker slot and a reserved slot. The skew follows, most significant bit first. After it come a spare slot, the field slot, the blanking slot and a closing even-parity slot.

Every slot lasts the same programmable number of clock cycles. That length is captured with the rest of the word when the start strobe is accepted. The serial line rests high between frames. A busy output tells the producer when the next word may be loaded. While a frame is in flight, further start strobes and changes on the parallel inputs have no effect.

Top module: `fsync_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in flight, `busy_o` is 0 and `fsync_o` is 1.
- R2: A `start_i` sampled high while `busy_o` is 0 captures all parallel inputs. From the next cycle on, `busy_o` is 1 and `fsync_o` drives slot 0, the marker, as 0.
- R3: Slot 1 (reserved) and slot 8 (spare, directly after the skew) are driven as 0.
- R4: Slots 2 to 7 carry `skew_i` most significant bit first: slot 2 is bit 5 and slot 7 is bit 0.
- R5: Slot 9 carries the field bit: 0 for the first field, 1 for the second field.
- R6: Slot 10 carries the vertical-blanking bit: 0 when blanking is off, 1 when it is on.
- R7: Slot 11 is even parity. The count of ones across the six skew bits, the spare, field, blanking and parity slots is even.
- R8: Every slot lasts exactly `bit_len_i + 1` clock cycles, using the value captured at the start.
- R9: `busy_o` stays high for exactly 12 × (`bit_len_i` + 1) cycles. It falls in the cycle after the parity slot ends, and a start in that cycle is accepted.
- R10: A start strobe while busy is ignored. Input changes after capture leave the frame in flight unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Load strobe, accepted only while idle |
| skew_i | input | 6 | Sub-line phase value to send |
| field_i | input | 1 | Field identifier (0 = first, 1 = second) |
| vblank_i | input | 1 | Vertical blanking flag (1 = on) |
| bit_len_i | input | 4 | Slot length minus one, in clock cycles |
| fsync_o | output | 1 | Serial front sync line, idles high |
| busy_o | output | 1 | High while a frame is being sent |

## Verification
The hardest situations to reach are those where a new request meets a frame at its edges. One is a start strobe in the very last cycle of the parity slot, which must be ignored. The other is a start in the first idle cycle, which must be taken at once. The stimulus drives these cases on purpose by chaining frames back to back with no gap. During frames marked for disturbance, the bench also raises start at random and scrambles every parallel input. It then compares the whole slot stream cycle by cycle against a word predicted from the values captured at the start. Slot lengths of one cycle and of sixteen cycles are both covered, so both the shortest and the longest timer wrap are exercised.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

  typedef enum logic [2:0] {
    SLOT_MARK,
    SLOT_RSV,
    SLOT_SKEW,
    SLOT_SPARE,
    SLOT_FIELD,
    SLOT_VBLK,
    SLOT_PAR
  } slot_kind_e;

  // Total number of slots for a given reserved count and skew width:
  // marker + reserved + skew + spare + field + vblank + parity
  function automatic int frame_slots(int rsv_n, int skew_w);
    return 1 + rsv_n + skew_w + 4;
  endfunction

  function automatic slot_kind_e kind_of(int idx, int rsv_n, int skew_w);
    if (idx == 0)                         return SLOT_MARK;
    else if (idx <= rsv_n)                return SLOT_RSV;
    else if (idx <= rsv_n + skew_w)       return SLOT_SKEW;
    else if (idx == rsv_n + skew_w + 1)   return SLOT_SPARE;
    else if (idx == rsv_n + skew_w + 2)   return SLOT_FIELD;
    else if (idx == rsv_n + skew_w + 3)   return SLOT_VBLK;
    else                                  return SLOT_PAR;
  endfunction

endpackage

// File: rtl/fsync_frame_builder.sv
module fsync_frame_builder #(
  parameter int SKEW_W = 6,
  parameter int RSV_N  = 1,
  localparam int NSLOT = fsync_pkg::frame_slots(RSV_N, SKEW_W)
) (
  input  logic [SKEW_W-1:0] skew_i,
  input  logic              field_i,
  input  logic              vblank_i,
  output logic [NSLOT-1:0]  frame_o
);

  logic par_bit;

  // even parity: spare slot is constant zero, so it adds nothing
  assign par_bit = ^{skew_i, field_i, vblank_i};

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam fsync_pkg::slot_kind_e KIND = fsync_pkg::kind_of(g, RSV_N, SKEW_W);
    if (KIND == fsync_pkg::SLOT_SKEW) begin : g_skew
      assign frame_o[g] = skew_i[SKEW_W + RSV_N - g];
    end else if (KIND == fsync_pkg::SLOT_FIELD) begin : g_fld
      assign frame_o[g] = field_i;
    end else if (KIND == fsync_pkg::SLOT_VBLK) begin : g_vb
      assign frame_o[g] = vblank_i;
    end else if (KIND == fsync_pkg::SLOT_PAR) begin : g_par
      assign frame_o[g] = par_bit;
    end else begin : g_zero
      assign frame_o[g] = 1'b0;
    end
  end

endmodule

// File: rtl/fsync_bit_timer.sv
module fsync_bit_timer #(
  parameter int LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             slot_end_o
);

  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] cyc_q, cyc_d;
  logic             wrap;

  assign wrap       = (cyc_q == len_q);
  assign slot_end_o = run_i && wrap;

  always_comb begin
    len_d = len_q;
    cyc_d = cyc_q;
    if (load_i) begin
      len_d = len_i;
      cyc_d = '0;
    end else if (run_i) begin
      cyc_d = wrap ? '0 : cyc_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      cyc_q <= '0;
    end else begin
      len_q <= len_d;
      cyc_q <= cyc_d;
    end
  end

  // R8
  cyc_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cyc_q <= len_q);

  // R8
  cyc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && cyc_q != len_q) |=> cyc_q == $past(cyc_q) + 1'b1);

endmodule

// File: rtl/fsync_slot_seq.sv
module fsync_slot_seq #(
  parameter int NSLOT = 12,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              last_o
);

  logic [SLOT_W-1:0] slot_q, slot_d;

  assign last_o = (slot_q == SLOT_W'(NSLOT - 1));
  assign slot_o = slot_q;

  always_comb begin
    slot_d = slot_q;
    if (load_i)
      slot_d = '0;
    else if (adv_i && !last_o)
      slot_d = slot_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= slot_d;
  end

  // R8
  slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(slot_q));

endmodule

// File: rtl/fsync_frame_tx.sv
module fsync_frame_tx #(
  parameter int SKEW_W = 6,
  parameter int RSV_N  = 1,
  parameter int LEN_W  = 4,
  localparam int NSLOT  = fsync_pkg::frame_slots(RSV_N, SKEW_W),
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SKEW_W-1:0] skew_i,
  input  logic              field_i,
  input  logic              vblank_i,
  input  logic [LEN_W-1:0]  bit_len_i,
  output logic              fsync_o,
  output logic              busy_o
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  logic              busy_q, busy_d;
  logic [NSLOT-1:0]  sh_q, sh_d;
  logic [NSLOT-1:0]  frame_w;
  logic              accept;
  logic              slot_end;
  logic              last_slot;
  logic [SLOT_W-1:0] slot_idx;

  assign accept = start_i && !busy_q;

  fsync_frame_builder #(.SKEW_W(SKEW_W), .RSV_N(RSV_N)) u_build (
    .skew_i  (skew_i),
    .field_i (field_i),
    .vblank_i(vblank_i),
    .frame_o (frame_w)
  );

  fsync_bit_timer #(.LEN_W(LEN_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_q),
    .load_i    (accept),
    .run_i     (busy_q),
    .len_i     (bit_len_i),
    .slot_end_o(slot_end)
  );

  fsync_slot_seq #(.NSLOT(NSLOT)) u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_n_q),
    .load_i(accept),
    .adv_i (slot_end),
    .slot_o(slot_idx),
    .last_o(last_slot)
  );

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    if (accept) begin
      busy_d = 1'b1;
      sh_d   = frame_w;
    end else if (slot_end) begin
      sh_d = sh_q >> 1;
      if (last_slot) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) begin
      busy_q <= 1'b0;
      sh_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
    end
  end

  assign fsync_o = busy_q ? sh_q[0] : 1'b1;
  assign busy_o  = busy_q;

  // R2
  marker_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    accept |=> (busy_o && !fsync_o));

  // R9
  busy_end_last_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    $fell(busy_q) |-> $past(slot_idx) == SLOT_W'(NSLOT - 1));

  // R10
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (busy_q && start_i && !slot_end) |=> $stable(sh_q));

  // R1
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (!busy_q && !start_i) |=> fsync_o);

endmodule

// File: tb/fsync_frame_tx_tb.sv
`timescale 1ns/1ps
module fsync_frame_tx_tb_top;

  localparam int SKEW_W = 6;
  localparam int RSV_N  = 1;
  localparam int LEN_W  = 4;
  localparam int NSLOT  = 1 + RSV_N + SKEW_W + 4;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic              start_i;
  logic [SKEW_W-1:0] skew_i;
  logic              field_i;
  logic              vblank_i;
  logic [LEN_W-1:0]  bit_len_i;
  logic              fsync_o;
  logic              busy_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  fsync_frame_tx dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .skew_i   (skew_i),
    .field_i  (field_i),
    .vblank_i (vblank_i),
    .bit_len_i(bit_len_i),
    .fsync_o  (fsync_o),
    .busy_o   (busy_o)
  );

  task automatic chk(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // expected slot value derived from the requirement list
  function automatic logic exp_bit(int s, logic [SKEW_W-1:0] sk, logic f, logic v);
    if (s == 0)                    return 1'b0;             // R2 marker
    if (s <= RSV_N)                return 1'b0;             // R3 reserved
    if (s <= RSV_N + SKEW_W)       return sk[SKEW_W + RSV_N - s]; // R4
    if (s == RSV_N + SKEW_W + 1)   return 1'b0;             // R3 spare
    if (s == RSV_N + SKEW_W + 2)   return f;                // R5
    if (s == RSV_N + SKEW_W + 3)   return v;                // R6
    return ^{sk, f, v};                                     // R7
  endfunction

  function automatic string req_of(int s);
    if (s == 0)                  return "R2 marker";
    if (s <= RSV_N)              return "R3 reserved";
    if (s <= RSV_N + SKEW_W)     return "R4 skew";
    if (s == RSV_N + SKEW_W + 1) return "R3 spare";
    if (s == RSV_N + SKEW_W + 2) return "R5 field";
    if (s == RSV_N + SKEW_W + 3) return "R6 vblank";
    return "R7 parity";
  endfunction

  task automatic run_frame(logic [SKEW_W-1:0] sk, logic f, logic v,
                           logic [LEN_W-1:0] len, bit disturb);
    int per;
    per       = int'(len) + 1;
    skew_i    = sk;
    field_i   = f;
    vblank_i  = v;
    bit_len_i = len;
    start_i   = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NSLOT * per; c++) begin
      int s;
      s = c / per;
      chk(disturb ? {"R10/R8/", req_of(s)} : {"R8/", req_of(s)},
          fsync_o, exp_bit(s, sk, f, v));
      chk("R9 busy in frame", busy_o, 1'b1);
      if (disturb && (($urandom_range(0, 2) == 0) || c == NSLOT * per - 1)) begin
        start_i   = 1'b1;
        skew_i    = SKEW_W'($urandom);
        field_i   = 1'($urandom);
        vblank_i  = 1'($urandom);
        bit_len_i = LEN_W'($urandom);
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk("R9 busy falls after parity", busy_o, 1'b0);
    chk("R1 idle high after frame", fsync_o, 1'b1);
  endtask

  task automatic idle_gap(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R1 idle busy low", busy_o, 1'b0);
      chk("R1 idle line high", fsync_o, 1'b1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_ni    = 1'b0;
    start_i   = 1'b0;
    skew_i    = '0;
    field_i   = 1'b0;
    vblank_i  = 1'b0;
    bit_len_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", busy_o, 1'b0);
    chk("R1 reset line", fsync_o, 1'b1);
    rst_ni = 1'b1;
    idle_gap(4);

    // directed corners
    run_frame(6'h00, 1'b0, 1'b0, 4'd0,  1'b0);  // all zero, one-cycle slots
    run_frame(6'h3F, 1'b1, 1'b1, 4'd0,  1'b0);  // back to back, all ones
    run_frame(6'h2A, 1'b1, 1'b0, 4'd15, 1'b0);  // longest slot
    idle_gap(2);
    run_frame(6'h15, 1'b0, 1'b1, 4'd3,  1'b1);  // strobes and input churn
    run_frame(6'h01, 1'b0, 1'b0, 4'd1,  1'b1);  // accepted right after busy falls
    idle_gap(1);

    // constrained random frames
    for (int k = 0; k < 40; k++) begin
      run_frame(SKEW_W'($urandom), 1'($urandom), 1'($urandom),
                LEN_W'($urandom_range(0, 7)), ($urandom_range(0, 1) == 1));
      if ($urandom_range(0, 2) == 0) idle_gap($urandom_range(1, 3));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule